// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by walking a descriptor tree held in memory. A request carries the logical address, a supervisor flag and a write flag. The walker picks the user or supervisor root table base and reads a root descriptor, then a pointer descriptor, then a page descriptor. If the page descriptor is indirect, it reads one more descriptor. It checks each descriptor's type and the protection bits. On success it writes back any descriptor whose used bit was clear, and on a write it also sets the page's modified bit. It then returns the physical address, a small attribute field and a fault flag.

The page size is chosen per request from the translation control input: 4 KiB or 8 KiB. The page size changes how many logical address bits index the page table and how the page table base is aligned. When translation is disabled, the logical address passes straight through without any memory traffic. All descriptor reads and writes use a single 32-bit memory port with a valid/ready request handshake and one access in flight at a time.

Top module: `page_walk_unit`

## Requirements
- R1: When xlateCtl bit 15 is 0 at request time, the response has rspPhys equal to reqAddr, rspAttr 0 and rspFault 0, and no memory access is made.
- R2: The first read goes to {root[31:9], reqAddr[31:25], 2'b00}. root is superRoot when reqSuper is 1 and userRoot otherwise.
- R3: The pointer descriptor is read from {rootDesc[31:9], va[24:18], 2'b00}. The page descriptor is read from {ptrDesc[31:8], va[17:12], 2'b00} when xlateCtl bit 14 is 0 (4 KiB), and from {ptrDesc[31:7], va[17:13], 2'b00} when bit 14 is 1 (8 KiB).
- R4: The physical address is {pageDesc[31:12], va[11:0]} for 4 KiB pages and {pageDesc[31:13], va[12:0]} for 8 KiB pages.
- R5: A root or pointer descriptor with bit 1 clear, or a page descriptor with bits 1:0 equal to 00, ends the walk with a fault and no further reads.
- R6: A write request faults if bit 2 (write protect) is set in the root, pointer or final page descriptor. A user request faults if bit 7 (supervisor only) of the final page descriptor is set.
- R7: A page descriptor with bits 1:0 equal to 10 is indirect. The walker then reads the final page descriptor from {desc[31:2], 2'b00}. A second indirect descriptor faults.
- R8: A faulting walk writes no descriptor, and its response carries rspPhys 0 and rspAttr 0.
- R9: After a successful walk, the walker writes back each traversed descriptor whose bit 3 (used) is clear, with bit 3 set, in the order root, pointer, page. On a write request, the page descriptor also gets bit 4 (modified) set. A descriptor that needs no change is not written.
- R10: On success, rspAttr is {pageDesc[7], pageDesc[6:5], wp}. Here wp is the OR of bit 2 over the root, pointer and page descriptors.
- R11: memReqValid, memAddr and memWrite stay stable until memReqReady. No new request is issued while an access is outstanding. busy is high from the accepting edge until after the one-cycle rspValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, accepted when busy is low |
| reqAddr | input | 32 | Logical address |
| reqSuper | input | 1 | 1 for a supervisor access |
| reqWrite | input | 1 | 1 for a write access |
| userRoot | input | 32 | Root table base for user accesses |
| superRoot | input | 32 | Root table base for supervisor accesses |
| xlateCtl | input | 16 | Bit 15 enables translation, bit 14 selects 8 KiB pages |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | One-cycle result strobe |
| rspPhys | output | 32 | Physical address |
| rspAttr | output | 4 | {supervisor-only, cache mode[1:0], write protected} |
| rspFault | output | 1 | Walk ended in a fault (valid with rspValid) |
| memReqValid | output | 1 | Memory access request |
| memReqReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | 1 for a descriptor write |
| memAddr | output | 32 | Descriptor address |
| memWdata | output | 32 | Descriptor write data |
| memRspValid | input | 1 | Access completed (read data valid for reads) |
| memRdata | input | 32 | Read data |

## Verification
The hardest path to reach from the ports is a walk that passes through an indirect page descriptor and then has to update a descriptor other than the one it fetched first. A close second is a fault raised by write protection at an upper level after all three reads succeeded, where every write-back must be suppressed. The bench builds descriptor trees in its memory model for both cases and predicts the exact number of reads and writes for each walk. After the walk it reads back the indirect descriptor and the final descriptor to confirm which one changed. The memory model varies its accept and response latency so that the held-request and single-outstanding rules are exercised.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;
  localparam int AW        = 32;
  localparam int IDX_BITS  = 7;
  localparam int ROOT_LSB  = AW - IDX_BITS;
  localparam int PTR_LSB   = ROOT_LSB - IDX_BITS;
  localparam int TBL_ALIGN = IDX_BITS + 2;
  localparam int PG4_SHIFT = 12;
  localparam int PG8_SHIFT = 13;
  localparam int EN_BIT    = 15;
  localparam int PSZ_BIT   = 14;
  localparam int B_WP      = 2;
  localparam int B_USED    = 3;
  localparam int B_MOD     = 4;
  localparam int CM_LSB    = 5;
  localparam int B_SUP     = 7;
  localparam int ATTR_W    = 4;

  typedef enum logic [1:0] {LV_ROOT, LV_PTR, LV_PAGE, LV_IND} level_e;

  typedef struct packed {
    logic   capture;
    logic   load;
    logic   write;
    logic   faulted;
    level_e lvl;
  } walk_ctl_t;

  typedef struct packed {
    logic       enabled;
    logic       typeBad;
    logic       typeInd;
    logic       protFault;
    logic [2:0] wbNeed;
  } walk_sts_t;
endpackage

// File: rtl/pwalk_dpath.sv
module pwalk_dpath
  import pwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walk_ctl_t         ctl,
  output walk_sts_t         sts,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqSuper,
  input  logic              reqWrite,
  input  logic [AW-1:0]     userRoot,
  input  logic [AW-1:0]     superRoot,
  input  logic [15:0]       xlateCtl,
  input  logic [AW-1:0]     memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [AW-1:0]     memWdata,
  output logic [AW-1:0]     rspPhys,
  output logic [ATTR_W-1:0] rspAttr
);
  logic [AW-1:0] va, dRoot, dPtr, dPage, pageAddr;
  logic [AW-1:TBL_ALIGN] rootBase;
  logic isSup, isWr, pg8, en;
  logic [AW-1:0] rootAddr, ptrAddr, pageIdxAddr, indAddr, physRaw;
  logic wpAny;
  logic unusedBits;

  assign unusedBits = ^{xlateCtl[13:0], userRoot[TBL_ALIGN-1:0], superRoot[TBL_ALIGN-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      va <= '0; isSup <= 1'b0; isWr <= 1'b0; pg8 <= 1'b0; en <= 1'b0;
      rootBase <= '0; dRoot <= '0; dPtr <= '0; dPage <= '0; pageAddr <= '0;
    end else begin
      if (ctl.capture) begin
        va       <= reqAddr;
        isSup    <= reqSuper;
        isWr     <= reqWrite;
        pg8      <= xlateCtl[PSZ_BIT];
        en       <= xlateCtl[EN_BIT];
        rootBase <= reqSuper ? superRoot[AW-1:TBL_ALIGN] : userRoot[AW-1:TBL_ALIGN];
      end
      if (ctl.load) begin
        case (ctl.lvl)
          LV_ROOT: dRoot <= memRdata;
          LV_PTR:  dPtr  <= memRdata;
          LV_PAGE: begin dPage <= memRdata; pageAddr <= pageIdxAddr; end
          default: begin dPage <= memRdata; pageAddr <= indAddr; end
        endcase
      end
    end
  end

  assign rootAddr = {rootBase, va[AW-1:ROOT_LSB], 2'b00};
  assign ptrAddr  = {dRoot[AW-1:TBL_ALIGN], va[ROOT_LSB-1:PTR_LSB], 2'b00};
  assign indAddr  = {dPage[AW-1:2], 2'b00};
  assign pageIdxAddr = pg8 ? {dPtr[AW-1:PTR_LSB-PG8_SHIFT+2], va[PTR_LSB-1:PG8_SHIFT], 2'b00}
                           : {dPtr[AW-1:PTR_LSB-PG4_SHIFT+2], va[PTR_LSB-1:PG4_SHIFT], 2'b00};

  always_comb begin
    case (ctl.lvl)
      LV_ROOT: memAddr = rootAddr;
      LV_PTR:  memAddr = ptrAddr;
      LV_PAGE: memAddr = ctl.write ? pageAddr : pageIdxAddr;
      default: memAddr = indAddr;
    endcase
    case (ctl.lvl)
      LV_ROOT: memWdata = dRoot | (AW'(1) << B_USED);
      LV_PTR:  memWdata = dPtr | (AW'(1) << B_USED);
      default: memWdata = dPage | (AW'(1) << B_USED) | (AW'(isWr) << B_MOD);
    endcase
  end

  // type decode of the word returning from memory at the current level
  always_comb begin
    if (ctl.lvl == LV_ROOT || ctl.lvl == LV_PTR) begin
      sts.typeBad = ~memRdata[1];
      sts.typeInd = 1'b0;
    end else begin
      sts.typeBad = (memRdata[1:0] == 2'b00);
      sts.typeInd = (memRdata[1:0] == 2'b10);
    end
  end

  assign wpAny         = dRoot[B_WP] | dPtr[B_WP] | dPage[B_WP];
  assign sts.enabled   = en;
  assign sts.protFault = (isWr & wpAny) | (~isSup & dPage[B_SUP]);
  assign sts.wbNeed    = {~dPage[B_USED] | (isWr & ~dPage[B_MOD]), ~dPtr[B_USED], ~dRoot[B_USED]};

  always_comb begin
    if (!en)      physRaw = va;
    else if (pg8) physRaw = {dPage[AW-1:PG8_SHIFT], va[PG8_SHIFT-1:0]};
    else          physRaw = {dPage[AW-1:PG4_SHIFT], va[PG4_SHIFT-1:0]};
  end

  assign rspPhys = ctl.faulted ? '0 : physRaw;
  assign rspAttr = (ctl.faulted || !en) ? '0
                 : {dPage[B_SUP], dPage[CM_LSB+1:CM_LSB], wpAny};
endmodule

// File: rtl/pwalk_ctrl.sv
module pwalk_ctrl
  import pwalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  walk_sts_t sts,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output walk_ctl_t ctl,
  output logic      busy,
  output logic      rspValid,
  output logic      memReqValid,
  output logic      memWrite
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_RD, ST_RWAIT, ST_CHK, ST_WPICK, ST_WR, ST_WWAIT, ST_DONE
  } state_e;

  state_e state;
  level_e lvl;
  logic faulted;
  logic [2:0] wbMask;

  assign ctl.capture = (state == ST_IDLE) && reqValid;
  assign ctl.load    = (state == ST_RWAIT) && memRspValid;
  assign ctl.write   = (state == ST_WR) || (state == ST_WWAIT);
  assign ctl.faulted = faulted;
  assign ctl.lvl     = lvl;

  assign busy        = (state != ST_IDLE);
  assign rspValid    = (state == ST_DONE);
  assign memReqValid = (state == ST_RD) || (state == ST_WR);
  assign memWrite    = (state == ST_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; lvl <= LV_ROOT; faulted <= 1'b0; wbMask <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_START; faulted <= 1'b0; lvl <= LV_ROOT;
        end
        ST_START: state <= sts.enabled ? ST_RD : ST_DONE;
        ST_RD: if (memReqReady) state <= ST_RWAIT;
        ST_RWAIT: if (memRspValid) begin
          if (sts.typeBad) begin
            faulted <= 1'b1; state <= ST_DONE;
          end else begin
            case (lvl)
              LV_ROOT: begin lvl <= LV_PTR;  state <= ST_RD; end
              LV_PTR:  begin lvl <= LV_PAGE; state <= ST_RD; end
              LV_PAGE: if (sts.typeInd) begin lvl <= LV_IND; state <= ST_RD; end
                       else state <= ST_CHK;
              default: if (sts.typeInd) begin faulted <= 1'b1; state <= ST_DONE; end
                       else state <= ST_CHK;
            endcase
          end
        end
        ST_CHK: if (sts.protFault) begin
          faulted <= 1'b1; state <= ST_DONE;
        end else begin
          wbMask <= sts.wbNeed; state <= ST_WPICK;
        end
        ST_WPICK: begin
          if (wbMask[0])      begin lvl <= LV_ROOT; state <= ST_WR; end
          else if (wbMask[1]) begin lvl <= LV_PTR;  state <= ST_WR; end
          else if (wbMask[2]) begin lvl <= LV_PAGE; state <= ST_WR; end
          else state <= ST_DONE;
        end
        ST_WR: if (memReqReady) state <= ST_WWAIT;
        ST_WWAIT: if (memRspValid) begin
          case (lvl)
            LV_ROOT: wbMask[0] <= 1'b0;
            LV_PTR:  wbMask[1] <= 1'b0;
            default: wbMask[2] <= 1'b0;
          endcase
          state <= ST_WPICK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_walk_unit.sv
module page_walk_unit
  import pwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqSuper,
  input  logic              reqWrite,
  input  logic [AW-1:0]     userRoot,
  input  logic [AW-1:0]     superRoot,
  input  logic [15:0]       xlateCtl,
  output logic              busy,
  output logic              rspValid,
  output logic [AW-1:0]     rspPhys,
  output logic [ATTR_W-1:0] rspAttr,
  output logic              rspFault,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memWrite,
  output logic [AW-1:0]     memAddr,
  output logic [AW-1:0]     memWdata,
  input  logic              memRspValid,
  input  logic [AW-1:0]     memRdata
);
  walk_ctl_t ctlBus;
  walk_sts_t stsBus;

  pwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sts(stsBus),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .ctl(ctlBus),
    .busy(busy), .rspValid(rspValid), .memReqValid(memReqValid), .memWrite(memWrite)
  );

  pwalk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .sts(stsBus),
    .reqAddr(reqAddr), .reqSuper(reqSuper), .reqWrite(reqWrite),
    .userRoot(userRoot), .superRoot(superRoot), .xlateCtl(xlateCtl),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .rspPhys(rspPhys), .rspAttr(rspAttr)
  );

  assign rspFault = ctlBus.faulted;
endmodule

// File: rtl/page_walk_chk.sv
module page_walk_chk
  import pwalk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [AW-1:0]     reqAddr,
  input logic [15:0]       xlateCtl,
  input logic              busy,
  input logic              rspValid,
  input logic [AW-1:0]     rspPhys,
  input logic [ATTR_W-1:0] rspAttr,
  input logic              rspFault,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memWrite,
  input logic [AW-1:0]     memAddr,
  input logic              memRspValid
);
  logic pending, wroteAny, touchedMem, enSaved;
  logic [AW-1:0] vaSaved;
  logic unusedCtl;
  assign unusedCtl = ^{xlateCtl[EN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0; wroteAny <= 1'b0; touchedMem <= 1'b0;
      enSaved <= 1'b0; vaSaved <= '0;
    end else begin
      if (memReqValid && memReqReady) pending <= 1'b1;
      else if (memRspValid) pending <= 1'b0;
      if (reqValid && !busy) begin
        wroteAny <= 1'b0; touchedMem <= 1'b0;
        enSaved <= xlateCtl[EN_BIT]; vaSaved <= reqAddr;
      end else if (memReqValid && memReqReady) begin
        touchedMem <= 1'b1;
        if (memWrite) wroteAny <= 1'b1;
      end
    end
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !enSaved |-> rspPhys == vaSaved && !rspFault && !touchedMem);

  p_fault_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> !wroteAny && rspPhys == '0 && rspAttr == '0);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr) && $stable(memWrite));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !memReqValid);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && !busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !rspValid);
endmodule

bind page_walk_unit page_walk_chk u_chk (.*);

// File: tb/test_page_walk_unit.sv
`timescale 1ns/1ps
module test_page_walk_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqSuper = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] userRoot = 32'h0001_0000, superRoot = 32'h0002_0000;
  logic [15:0] xlateCtl = '0;
  logic busy, rspValid, rspFault, memReqValid, memWrite;
  logic [31:0] rspPhys, memAddr, memWdata;
  logic [3:0] rspAttr;
  logic memReqReady, memRspValid;
  logic [31:0] memRdata;

  always #10 clk = ~clk;

  page_walk_unit i_page_walk_unit (.*);

  typedef struct packed {
    logic [31:0] phys;
    logic [3:0]  attr;
    logic        fault;
    logic [2:0]  nrd;
    logic [2:0]  nwr;
  } exp_t;

  logic [31:0] mem [logic [31:0]];
  exp_t expQ[$];
  string tagQ[$];
  int nChecks = 0, nFail = 0;
  int rdCount = 0, wrCount = 0;
  int unsigned seq = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] aRoot(input logic [31:0] r, input logic [31:0] va);
    return {r[31:9], va[31:25], 2'b00};
  endfunction
  function automatic logic [31:0] aPtr(input logic [31:0] d1, input logic [31:0] va);
    return {d1[31:9], va[24:18], 2'b00};
  endfunction
  function automatic logic [31:0] aPage(input logic [31:0] d2, input logic [31:0] va, input logic p8);
    return p8 ? {d2[31:7], va[17:13], 2'b00} : {d2[31:8], va[17:12], 2'b00};
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] va, input logic sup, input logic wr,
                                 input logic [15:0] ctl);
    exp_t e;
    logic [31:0] d1, d2, d3;
    logic wp;
    e = '0;
    if (!ctl[15]) begin e.phys = va; return e; end
    d1 = rd(aRoot(sup ? superRoot : userRoot, va)); e.nrd = 1;
    if (!d1[1]) begin e.fault = 1; return e; end
    d2 = rd(aPtr(d1, va)); e.nrd = 2;
    if (!d2[1]) begin e.fault = 1; return e; end
    d3 = rd(aPage(d2, va, ctl[14])); e.nrd = 3;
    if (d3[1:0] == 2'b00) begin e.fault = 1; return e; end
    if (d3[1:0] == 2'b10) begin
      d3 = rd({d3[31:2], 2'b00}); e.nrd = 4;
      if (d3[1:0] == 2'b00 || d3[1:0] == 2'b10) begin e.fault = 1; return e; end
    end
    wp = d1[2] | d2[2] | d3[2];
    if ((wr && wp) || (!sup && d3[7])) begin e.fault = 1; return e; end
    e.nwr = 3'(!d1[3]) + 3'(!d2[3]) + 3'(!d3[3] || (wr && !d3[4]));
    e.phys = ctl[14] ? {d3[31:13], va[12:0]} : {d3[31:12], va[11:0]};
    e.attr = {d3[7], d3[6:5], wp};
    return e;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic submit(input logic [31:0] va, input logic sup, input logic wr,
                        input logic [15:0] ctl, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    expQ.push_back(model(va, sup, wr, ctl));
    tagQ.push_back(tag);
    rdCount = 0; wrCount = 0;
    reqAddr = va; reqSuper = sup; reqWrite = wr; xlateCtl = ctl; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // memory model with varying latency
  initial begin
    logic [31:0] a, d;
    logic w;
    memReqReady = 1'b0; memRspValid = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (seq % 3) @(negedge clk);
        memReqReady = 1'b1; a = memAddr; w = memWrite; d = memWdata;
        @(negedge clk);
        memReqReady = 1'b0;
        if (w) begin mem[a] = d; wrCount++; end
        else begin memRdata = rd(a); rdCount++; end
        repeat (seq % 2) @(negedge clk);
        seq++;
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      exp_t e;
      string t;
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 32'h1, 32'h0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rspFault == e.fault, {t, " fault"}, 32'(rspFault), 32'(e.fault));
        chk(rspPhys == e.phys, {t, " phys"}, rspPhys, e.phys);
        chk(rspAttr == e.attr, {t, " attr"}, 32'(rspAttr), 32'(e.attr));
        chk(rdCount == int'(e.nrd), {t, " reads"}, 32'(rdCount), 32'(e.nrd));
        chk(wrCount == int'(e.nwr), {t, " writes"}, 32'(wrCount), 32'(e.nwr));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  localparam logic [15:0] OFF = 16'h0000, C4K = 16'h8000, C8K = 16'hC000;
  localparam logic [31:0] VA2 = 32'h0A0C_5ABC, VAS = 32'h0A0C_6ABC, VA8 = 32'h1110_3456;
  localparam logic [31:0] VAW = 32'h0400_0000, VAB = 32'h0600_0000, VAI = 32'h0A0C_8123;
  localparam logic [31:0] VAD = 32'h0A0C_9000, VAN = 32'h0A0C_7000, VAL = 32'h7E00_0000;

  initial begin
    // descriptor trees
    mem[aRoot(userRoot, VA2)] = 32'h0004_0002;
    mem[aPtr(32'h0004_0002, VA2)] = 32'h0005_0002;
    mem[aPage(32'h0005_0002, VA2, 1'b0)] = 32'h0ABC_D021;
    mem[aPage(32'h0005_0002, VAS, 1'b0)] = 32'h0444_4081;
    mem[aPage(32'h0005_0002, VAI, 1'b0)] = 32'h0009_0002;
    mem[32'h0009_0000] = 32'h0666_6001;
    mem[aPage(32'h0005_0002, VAD, 1'b0)] = 32'h0009_1002;
    mem[32'h0009_1000] = 32'h0009_0002;
    mem[aRoot(superRoot, VA2)] = 32'h0004_0202;
    mem[aPtr(32'h0004_0202, VA2)] = 32'h0005_0102;
    mem[aPage(32'h0005_0102, VA2, 1'b0)] = 32'h0777_7081;
    mem[aRoot(userRoot, VA8)] = 32'h0004_0402;
    mem[aPtr(32'h0004_0402, VA8)] = 32'h0006_0002;
    mem[aPage(32'h0006_0002, VA8, 1'b1)] = 32'h2222_E003;
    mem[aPage(32'h0006_0002, VA8, 1'b0)] = 32'h3333_3001;
    mem[aRoot(userRoot, VAW)] = 32'h0004_0602;
    mem[aPtr(32'h0004_0602, VAW)] = 32'h0007_0007;
    mem[aPage(32'h0007_0007, VAW, 1'b0)] = 32'h0555_5001;
    mem[aRoot(userRoot, VAB)] = 32'h0004_0801;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !rspValid && !memReqValid, "R11 reset idle", 32'({busy, rspValid, memReqValid}), 32'h0);
    rstN = 1'b1;

    submit(32'h1234_5678, 1'b0, 1'b0, OFF, "R1 bypass user");
    submit(32'hFEDC_BA98, 1'b1, 1'b1, OFF, "R1 bypass super write");
    submit(VA2, 1'b0, 1'b0, C4K, "R2 R3 R4 R9 R10 user 4K first walk");
    submit(VA2, 1'b0, 1'b0, C4K, "R9 repeat walk no write-back");
    submit(VA2, 1'b0, 1'b1, C4K, "R9 write sets modified");
    chk(rd(aPage(32'h0005_0002, VA2, 1'b0)) == 32'h0ABC_D039, "R9 page desc after write",
        rd(aPage(32'h0005_0002, VA2, 1'b0)), 32'h0ABC_D039);
    submit(VA2, 1'b1, 1'b0, C4K, "R2 supervisor root");
    submit(VAS, 1'b0, 1'b0, C4K, "R6 user to supervisor page");
    submit(VA8, 1'b0, 1'b0, C8K, "R3 R4 8K page");
    submit(VA8, 1'b0, 1'b0, C4K, "R3 R4 same address 4K");
    submit(VAL, 1'b0, 1'b0, C4K, "R5 invalid root entry");
    submit(VAB, 1'b0, 1'b0, C4K, "R5 root type 01");
    submit(VAN, 1'b0, 1'b0, C4K, "R5 invalid page entry");
    submit(VAW, 1'b0, 1'b1, C4K, "R6 R8 write through protected pointer");
    chk(rd(aPtr(32'h0004_0602, VAW)) == 32'h0007_0007, "R8 pointer desc untouched",
        rd(aPtr(32'h0004_0602, VAW)), 32'h0007_0007);
    submit(VAW, 1'b0, 1'b0, C4K, "R10 read protected page");
    submit(VAI, 1'b0, 1'b0, C4K, "R7 indirect page");
    chk(rd(32'h0009_0000) == 32'h0666_6009, "R7 target desc used set",
        rd(32'h0009_0000), 32'h0666_6009);
    chk(rd(aPage(32'h0005_0002, VAI, 1'b0)) == 32'h0009_0002, "R7 indirect desc untouched",
        rd(aPage(32'h0005_0002, VAI, 1'b0)), 32'h0009_0002);
    submit(VAD, 1'b0, 1'b0, C4K, "R7 double indirect fault");
    submit(VA2, 1'b0, 1'b1, C8K, "R3 R6 mode change write");

    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R11 all responses seen", 32'(expQ.size()), 32'h0);
    summary();
  end
endmodule